// File: doc/BRIEF.md
# Battery Sample Accumulation FIFO

This block gathers battery voltage and current readings on a programmable cadence while the gauge sits in its active sampling mode. At each sample point the current voltage and current values are added into a pair of wide running sums. Once a programmed number of pairs has been added, the two sums and the number of pairs behind them are written as one entry into a short FIFO. When a programmed number of entries has been written, a one-cycle completion pulse fires and a sticky completion flag rises. Sampling then stops until that flag is acknowledged or the mode controller withdraws the enable.

The cadence comes from a free-running millisecond tick. The spacing register counts in 10 ms steps, so an 8-bit value reaches 2550 ms. A downstream reader drains entries through a first-word-fall-through read port. Both acknowledging the flag and dropping the enable empty the FIFO and restart both the sums and the cadence timer.

Top module: `batt_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty (`fifo_count` 0, `fifo_empty` 1) and both `done_irq` and `done_sts` are low.
- R2: An entry written with a pairs setting N from 1 to 256 holds the signed sums of N consecutive sample points and a count of N. Each sum is SW+8 bits wide, so 256 full-scale samples of either sign are held exactly.
- R3: With spacing value P greater than 0, a sample point falls on the clock edge that carries the 10·P-th `ms_tick` since enable, clear or the previous sample point. With P equal to 0 there is a sample point on every enabled clock edge.
- R4: With the pairs setting at 0, every sample point writes an entry whose two sums and count are all 0.
- R5: When the number of entries written since the last clear reaches the target (the entries setting, with 0 read as 1 and values above DEPTH read as DEPTH), `done_irq` is high for exactly that one cycle and `done_sts` rises with it. `done_sts` stays high, and no further sample is taken, until it is cleared.
- R6: A cycle with `done_ack` high empties the FIFO, lowers `done_sts` and restarts the sums and the cadence timer.
- R7: While `en` is low the FIFO is held empty, `done_sts` is low and no sample is taken.
- R8: The read port shows the oldest entry while the FIFO is not empty. `rd_en` removes that entry, entries leave in the order they were written, and `rd_en` on an empty FIFO changes nothing.
- R9: When an entry is written and one is read in the same cycle, `fifo_count` is unchanged and both operations take effect.
- R10: A clear by `done_ack` or by a low `en` takes priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | High while the gauge is in its active sampling mode |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| v_in | input | SW | Signed battery voltage sample |
| i_in | input | SW | Signed battery current sample |
| cfg_pairs | input | 9 | Pairs summed per entry, 0 to 256 |
| cfg_spacing | input | 8 | Time between sample points in 10 ms steps |
| cfg_entries | input | $clog2(DEPTH)+1 | Entries needed for completion |
| done_ack | input | 1 | Acknowledge completion; clears FIFO and sums |
| rd_en | input | 1 | Remove the oldest entry |
| rd_v_sum | output | SW+8 | Voltage sum of the oldest entry |
| rd_i_sum | output | SW+8 | Current sum of the oldest entry |
| rd_cnt | output | 9 | Pair count of the oldest entry |
| fifo_count | output | $clog2(DEPTH)+1 | Entries held |
| fifo_empty | output | 1 | No entry held |
| done_irq | output | 1 | Completion pulse |
| done_sts | output | 1 | Sticky completion flag |

## Verification
Writing an entry and reading one can happen in the same cycle. A sample point that closes an entry can meet a reader that is already draining, and a clear can meet a pending read. The bench drives `rd_en` at random against short entry lengths and a sample point on every edge, so entries often land in the cycle of a read. It also raises `done_ack` and drops `en` while reads are pending. A reference queue in the bench applies the write, read and clear rules each cycle, and every cycle the count, the head entry and the completion signals are compared against that queue.

// File: rtl/batt_sample_fifo.sv
module batt_sample_fifo #(
  parameter int SW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = SW + 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = 9,
  localparam int TW   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 ms_tick,
  input  logic signed [SW-1:0] v_in,
  input  logic signed [SW-1:0] i_in,
  input  logic [CW-1:0]        cfg_pairs,
  input  logic [7:0]           cfg_spacing,
  input  logic [PW:0]          cfg_entries,
  input  logic                 done_ack,
  input  logic                 rd_en,
  output logic signed [AW-1:0] rd_v_sum,
  output logic signed [AW-1:0] rd_i_sum,
  output logic [CW-1:0]        rd_cnt,
  output logic [PW:0]          fifo_count,
  output logic                 fifo_empty,
  output logic                 done_irq,
  output logic                 done_sts
);

  logic signed [AW-1:0] mem_v [DEPTH];
  logic signed [AW-1:0] mem_i [DEPTH];
  logic [CW-1:0]        mem_c [DEPTH];
  logic [PW-1:0]        wr_ptr, rd_ptr;
  logic [PW:0]          occ, filled;
  logic [TW-1:0]        ms_cnt;
  logic signed [AW-1:0] acc_v, acc_i;
  logic [CW-1:0]        n;

  logic clr, run, ev, last, push, pop;
  logic [TW-1:0] thr;
  logic [PW:0]   target;
  logic signed [AW-1:0] sum_v, sum_i, push_v, push_i;
  logic [CW-1:0] n_nxt, push_c;

  assign clr    = !en || done_ack;
  assign run    = en && !done_sts && !done_ack;
  assign thr    = TW'(cfg_spacing) * TW'(10);
  assign ev     = run && ((thr == '0) || (ms_tick && ms_cnt == thr - TW'(1)));
  assign n_nxt  = n + CW'(1);
  assign last   = (cfg_pairs == '0) || (n_nxt >= cfg_pairs);
  assign push   = ev && last;
  assign pop    = rd_en && (occ != '0) && !clr;
  assign sum_v  = acc_v + AW'(v_in);
  assign sum_i  = acc_i + AW'(i_in);
  assign push_v = (cfg_pairs == '0) ? '0 : sum_v;
  assign push_i = (cfg_pairs == '0) ? '0 : sum_i;
  assign push_c = (cfg_pairs == '0) ? '0 : n_nxt;
  assign target = (cfg_entries == '0) ? (PW+1)'(1) :
                  (cfg_entries > (PW+1)'(DEPTH)) ? (PW+1)'(DEPTH) : cfg_entries;

  assign rd_v_sum   = mem_v[rd_ptr];
  assign rd_i_sum   = mem_i[rd_ptr];
  assign rd_cnt     = mem_c[rd_ptr];
  assign fifo_count = occ;
  assign fifo_empty = (occ == '0);

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr || ev) ms_cnt <= '0;
    else if (run && ms_tick) ms_cnt <= ms_cnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_v <= '0;
      acc_i <= '0;
      n     <= '0;
    end else if (ev) begin
      if (last) begin
        acc_v <= '0;
        acc_i <= '0;
        n     <= '0;
      end else begin
        acc_v <= sum_v;
        acc_i <= sum_i;
        n     <= n_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_v[wr_ptr] <= push_v;
      mem_i[wr_ptr] <= push_i;
      mem_c[wr_ptr] <= push_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      filled   <= '0;
      done_sts <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      occ      <= occ + (PW+1)'(push) - (PW+1)'(pop);
      done_irq <= 1'b0;
      if (push) begin
        filled <= filled + (PW+1)'(1);
        if (filled + (PW+1)'(1) == target) begin
          done_sts <= 1'b1;
          done_irq <= 1'b1;
        end
      end
    end
  end

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (PW+1)'(DEPTH));

  // R5
  irq_with_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> done_sts);

  // R5
  sts_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_sts) |-> done_irq);

  // R5
  frozen_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_sts && en && !done_ack) |=> (occ <= $past(occ) && !done_irq));

  // R7
  en_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (occ == '0 && !done_sts));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack |=> (occ == '0 && !done_sts));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && rd_en && !push) |=> (occ == '0));

endmodule

// File: tb/test_batt_sample_fifo.sv
module test_batt_sample_fifo;
  localparam int SW = 16, DEPTH = 8, AW = SW + 8, PW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, en = 0, ms_tick = 0, done_ack = 0, rd_en = 0;
  logic signed [SW-1:0] v_in = '0, i_in = '0;
  logic [8:0] cfg_pairs = 9'd1;
  logic [7:0] cfg_spacing = 8'd0;
  logic [PW:0] cfg_entries = (PW+1)'(1);
  logic signed [AW-1:0] rd_v_sum, rd_i_sum;
  logic [8:0] rd_cnt;
  logic [PW:0] fifo_count;
  logic fifo_empty, done_irq, done_sts;

  batt_sample_fifo #(.SW(SW), .DEPTH(DEPTH)) i_batt_sample_fifo (
    .clk, .rst_n, .en, .ms_tick, .v_in, .i_in, .cfg_pairs, .cfg_spacing,
    .cfg_entries, .done_ack, .rd_en, .rd_v_sum, .rd_i_sum, .rd_cnt,
    .fifo_count, .fifo_empty, .done_irq, .done_sts);

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  longint qv[$], qi[$], qc[$];
  longint m_av, m_ai, m_n, m_ms, m_filled;
  bit m_done, m_irq;

  function automatic longint target_of(input int e);
    if (e == 0) return 1;
    if (e > DEPTH) return DEPTH;
    return e;
  endfunction

  always @(posedge clk) begin
    bit clr, run, ev, pop, pushed;
    longint thr;
    if (!rst_n) begin
      qv.delete(); qi.delete(); qc.delete();
      m_av = 0; m_ai = 0; m_n = 0; m_ms = 0; m_filled = 0; m_done = 0; m_irq = 0;
    end else begin
      clr = !en || done_ack;
      run = en && !m_done && !done_ack;
      thr = longint'(cfg_spacing) * 10;
      ev  = run && (thr == 0 || (ms_tick && m_ms == thr - 1));
      pop = rd_en && qv.size() > 0 && !clr;
      m_irq = 0;
      pushed = 0;
      if (clr) begin
        qv.delete(); qi.delete(); qc.delete();
        m_ms = 0; m_n = 0; m_av = 0; m_ai = 0; m_filled = 0; m_done = 0;
      end else begin
        if (pop) begin
          void'(qv.pop_front()); void'(qi.pop_front()); void'(qc.pop_front());
        end
        if (ev) begin
          m_ms = 0;
          if (cfg_pairs == 0) begin
            qv.push_back(0); qi.push_back(0); qc.push_back(0); pushed = 1;
          end else begin
            m_av += longint'(v_in); m_ai += longint'(i_in); m_n++;
            if (m_n >= cfg_pairs) begin
              qv.push_back(m_av); qi.push_back(m_ai); qc.push_back(m_n); pushed = 1;
              m_av = 0; m_ai = 0; m_n = 0;
            end
          end
          if (pushed) begin
            m_filled++;
            if (m_filled == target_of(int'(cfg_entries))) begin
              m_done = 1; m_irq = 1;
            end
          end
        end else if (run && ms_tick) m_ms++;
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    check("R8 R9 count", longint'(fifo_count), longint'(qv.size()));
    check("R8 empty", longint'(fifo_empty), longint'(qv.size() == 0));
    check("R5 done_sts", longint'(done_sts), longint'(m_done));
    check("R5 done_irq", longint'(done_irq), longint'(m_irq));
    if (qv.size() > 0) begin
      check("R2 v_sum", longint'($signed(rd_v_sum)), qv[0]);
      check("R2 i_sum", longint'($signed(rd_i_sum)), qi[0]);
      check("R2 count", longint'(rd_cnt), qc[0]);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_model();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", longint'(fifo_count), 0);
    check("R1 empty", longint'(fifo_empty), 1);
    check("R1 irq", longint'(done_irq), 0);
    check("R1 sts", longint'(done_sts), 0);
    rst_n = 1;

    // R3: spacing 2 -> 20 ticks; ms_tick every cycle
    cfg_spacing = 8'd2; cfg_pairs = 9'd1; cfg_entries = (PW+1)'(1);
    ms_tick = 1; v_in = 16'sd7; i_in = -16'sd3; en = 1;
    for (int k = 1; k <= 20; k++) begin
      cyc();
      if (k == 19) check("R3 before interval", longint'(fifo_count), 0);
      if (k == 20) begin
        check("R3 at interval", longint'(fifo_count), 1);
        check("R5 irq pulse", longint'(done_irq), 1);
      end
    end
    cyc();
    check("R5 irq one cycle", longint'(done_irq), 0);
    check("R5 sts held", longint'(done_sts), 1);
    repeat (30) cyc();
    check("R5 frozen", longint'(fifo_count), 1);
    // R10: ack with read pending
    done_ack = 1; rd_en = 1;
    cyc();
    done_ack = 0; rd_en = 0;
    check("R6 ack clears", longint'(fifo_count), 0);
    check("R6 ack sts", longint'(done_sts), 0);

    // R4 zero pairs, spacing 0
    cfg_spacing = 0; cfg_pairs = 0; cfg_entries = (PW+1)'(3);
    repeat (4) cyc();
    check("R4 count field", longint'(rd_cnt), 0);
    check("R4 v zero", longint'(rd_v_sum), 0);
    check("R4 entries", longint'(fifo_count), 3);
    // R8 drain past empty
    rd_en = 1;
    repeat (5) cyc();
    check("R8 empty read", longint'(fifo_count), 0);
    rd_en = 0;
    en = 0;
    cyc();
    check("R7 en low", longint'(done_sts), 0);

    // R2 full-scale 256 pairs
    cfg_pairs = 9'd256; cfg_entries = (PW+1)'(2);
    v_in = 16'sd32767; i_in = -16'sd32768; en = 1;
    repeat (256) cyc();
    check("R2 max v", longint'($signed(rd_v_sum)), 64'sd32767 * 256);
    check("R2 min i", longint'($signed(rd_i_sum)), -64'sd32768 * 256);
    check("R2 256 count", longint'(rd_cnt), 256);
    en = 0;
    cyc();
    check("R7 cleared", longint'(fifo_count), 0);

    // Random with same-cycle write/read (R9) and clears (R10)
    for (int c = 0; c < 24; c++) begin
      cfg_spacing = 8'($urandom % 3);
      cfg_pairs   = 9'($urandom % 5);
      cfg_entries = (PW+1)'($urandom % 10);
      en = 1;
      for (int t = 0; t < 500; t++) begin
        ms_tick  = ($urandom % 2) == 0;
        v_in     = SW'($urandom);
        i_in     = SW'($urandom);
        rd_en    = ($urandom % 4) == 0;
        done_ack = done_sts && (($urandom % 20) == 0);
        if (($urandom % 300) == 0) en = ~en;
        cyc();
      end
      en = 0; done_ack = 0; rd_en = 0;
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule